// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts processor events in two 32-bit counters that share a single 64-bit counter word. The upper half is bits 63:32 and the lower half is bits 31:0. Each cycle the processor drives a set of event strobes and its current privilege level. The strobes are: a clock-cycle tick, a retired instruction, a data-cache access, a data-cache miss and a data-TLB miss. A single 64-bit control word picks one event code for each counter. It also holds privilege enables that are shared by both counters, and an interrupt enable.

Software reaches the block through a simple register port that reads and writes whole 64-bit words. There is no way to write one counter half alone: software reads the counter word, changes one half and writes the whole word back. To sample every N events, software loads the two's complement of N into a counter. When that counter wraps from all ones to zero, its sticky overflow flag is set. The flag raises the interrupt if the interrupt enable is on. A counter that is not in use is parked on a code that never counts.

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset both register words read as zero and `irq` is low.
- R2: The counter word (`reg_sel`=1) holds the upper counter in bits 63:32 and the lower counter in bits 31:0. A write replaces both halves, and a read returns what was last written plus any counted events.
- R3: A counter sets its overflow flag only on an increment that takes it from 0xFFFFFFFF to 0. The lower flag reads at control bit 32 and the upper flag at control bit 33.
- R4: Control word (`reg_sel`=0) layout: bit 0 is interrupt enable, bit 1 is supervisor enable, bit 2 is user enable, bit 3 is hypervisor enable. Bits 9:4 hold the lower event code and bits 16:11 hold the upper event code. Every other bit reads as zero.
- R5: `priv` is encoded 0 = user, 1 = supervisor, 2 = hypervisor, 3 = none. An event counts only when the enable bit for the current level is set, and the same bits gate both counters. Level 3 never counts.
- R6: Event code 0x00 counts the cycle strobe and code 0x01 counts the retired-instruction strobe, on either counter.
- R7: Event code 0x09 counts cache accesses on the lower counter and cache misses on the upper counter. Code 0x12 counts data-TLB misses on the upper counter and never counts on the lower counter.
- R8: The parking codes (0x1C for the upper counter, 0x14 for the lower counter) never count. Neither does any code not named in R6 or R7.
- R9: If a counter-word write and a counted event fall in the same cycle, the written value is stored, the increment is lost, and no overflow is flagged.
- R10: Overflow flags stay set until a control write with a 1 in the flag's bit position. Writing 0 leaves the flag unchanged. If a wrap happens in the same cycle as the clearing write, the flag stays set.
- R11: `irq` is high exactly when the interrupt enable is set and at least one overflow flag is set.
- R12: A counter loaded with -N (mod 2^32) sets its overflow flag on the N-th counted event and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the counter word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected word (combinational) |
| priv | input | 2 | Current privilege level |
| ev_cycle | input | 1 | Clock-cycle event strobe |
| ev_instr | input | 1 | Retired-instruction strobe |
| ev_cache_acc | input | 1 | Data-cache access strobe |
| ev_cache_miss | input | 1 | Data-cache miss strobe |
| ev_dtlb_miss | input | 1 | Data-TLB miss strobe |
| irq | output | 1 | Overflow interrupt |

## Verification
A decode fault in the event select or the privilege gate shows up in the counter word right after the cycle that gets the wrong event. One pulse gives a delta of one on the wrong half, or a missing delta. Faults in the wrap detector and the sticky flags show up in control bits 32/33 and on `irq` one cycle after the wrapping increment, or one cycle after a clearing write. The sweep drives every event code against every strobe on both halves and every enable pattern against every privilege level, so a misdecoded code is caught within a few cycles of its first use.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef struct packed {
        logic cycle;
        logic instr;
        logic cache_acc;
        logic cache_miss;
        logic dtlb_miss;
    } pmu_events_t;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_HYPV = 2'd2,
        PRIV_NONE = 2'd3
    } priv_t;

    localparam int EVC_CYCLES  = 'h00;
    localparam int EVC_INSTR   = 'h01;
    localparam int EVC_CACHE   = 'h09;
    localparam int EVC_DTLB    = 'h12;
    localparam int EVC_PARK_HI = 'h1C;
    localparam int EVC_PARK_LO = 'h14;

endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
    import pmu_pkg::*;
#(
    parameter int SEL_W    = 6,
    parameter bit IS_UPPER = 1'b0
) (
    input  logic [SEL_W-1:0] code,
    input  pmu_events_t      ev,
    output logic             hit
);

    always_comb begin
        hit = 1'b0;
        if (code == SEL_W'(EVC_CYCLES)) begin
            hit = ev.cycle;
        end else if (code == SEL_W'(EVC_INSTR)) begin
            hit = ev.instr;
        end else if (code == SEL_W'(EVC_CACHE)) begin
            hit = IS_UPPER ? ev.cache_miss : ev.cache_acc;
        end else if (code == SEL_W'(EVC_DTLB)) begin
            hit = IS_UPPER & ev.dtlb_miss;
        end
    end

endmodule

// File: rtl/pmu_cnt_slice.sv
module pmu_cnt_slice #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);

    always_comb begin
        wrap = 1'b0;
        if (wr) begin
            nxt = wval;
        end else if (inc) begin
            nxt  = cur + CNT_W'(1);
            wrap = &cur;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SEL_W      = 6,
    parameter int LO_SEL_LSB = 4,
    parameter int HI_SEL_LSB = 11,
    parameter int OVF_LSB    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [2*CNT_W-1:0]   reg_wdata,
    output logic [2*CNT_W-1:0]   reg_rdata,
    input  logic [1:0]           priv,
    input  logic                 ev_cycle,
    input  logic                 ev_instr,
    input  logic                 ev_cache_acc,
    input  logic                 ev_cache_miss,
    input  logic                 ev_dtlb_miss,
    output logic                 irq
);

    localparam int REG_W    = 2*CNT_W;
    localparam int N_CNT    = 2;
    localparam int IE_BIT   = 0;
    localparam int SUPV_BIT = 1;
    localparam int USER_BIT = 2;
    localparam int HYPV_BIT = 3;

    typedef struct packed {
        logic                        ie;
        logic                        en_supv;
        logic                        en_user;
        logic                        en_hypv;
        logic [N_CNT-1:0][SEL_W-1:0] sel;
        logic [N_CNT-1:0]            ovf;
        logic [N_CNT-1:0][CNT_W-1:0] cnt;
    } pmu_state_t;

    pmu_state_t s_d, s_q;

    pmu_events_t                 ev;
    logic                        priv_ok;
    logic                        wr_ctl, wr_cnt;
    logic [N_CNT-1:0]            hit, wrap;
    logic [N_CNT-1:0][CNT_W-1:0] cnt_nxt;
    logic [REG_W-1:0]            ctl_img;

    assign ev.cycle      = ev_cycle;
    assign ev.instr      = ev_instr;
    assign ev.cache_acc  = ev_cache_acc;
    assign ev.cache_miss = ev_cache_miss;
    assign ev.dtlb_miss  = ev_dtlb_miss;

    assign wr_ctl = reg_wr & ~reg_sel;
    assign wr_cnt = reg_wr &  reg_sel;

    // shared privilege gate for both counters
    always_comb begin
        case (priv_t'(priv))
            PRIV_USER: priv_ok = s_q.en_user;
            PRIV_SUPV: priv_ok = s_q.en_supv;
            PRIV_HYPV: priv_ok = s_q.en_hypv;
            default:   priv_ok = 1'b0;
        endcase
    end

    // index 0 = lower half, index 1 = upper half
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        pmu_event_sel #(
            .SEL_W    (SEL_W),
            .IS_UPPER (i == 1)
        ) u_sel (
            .code (s_q.sel[i]),
            .ev   (ev),
            .hit  (hit[i])
        );

        pmu_cnt_slice #(
            .CNT_W (CNT_W)
        ) u_slice (
            .cur  (s_q.cnt[i]),
            .inc  (hit[i] & priv_ok),
            .wr   (wr_cnt),
            .wval (reg_wdata[i*CNT_W +: CNT_W]),
            .nxt  (cnt_nxt[i]),
            .wrap (wrap[i])
        );

        localparam int PARK = (i == 1) ? EVC_PARK_HI : EVC_PARK_LO;

        // overflow flag only rises when the half has just wrapped to zero
        p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(s_q.ovf[i]) |-> (s_q.cnt[i] == '0));

        // a parked half never moves unless written
        p_parked_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_cnt && s_q.sel[i] == SEL_W'(PARK)) |=> $stable(s_q.cnt[i]));
    end

    always_comb begin
        s_d     = s_q;
        s_d.cnt = cnt_nxt;
        if (wr_ctl) begin
            s_d.ie      = reg_wdata[IE_BIT];
            s_d.en_supv = reg_wdata[SUPV_BIT];
            s_d.en_user = reg_wdata[USER_BIT];
            s_d.en_hypv = reg_wdata[HYPV_BIT];
            s_d.sel[0]  = reg_wdata[LO_SEL_LSB +: SEL_W];
            s_d.sel[1]  = reg_wdata[HI_SEL_LSB +: SEL_W];
            s_d.ovf     = s_q.ovf & ~reg_wdata[OVF_LSB +: N_CNT];
        end
        s_d.ovf = s_d.ovf | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_img                         = '0;
        ctl_img[IE_BIT]                 = s_q.ie;
        ctl_img[SUPV_BIT]               = s_q.en_supv;
        ctl_img[USER_BIT]               = s_q.en_user;
        ctl_img[HYPV_BIT]               = s_q.en_hypv;
        ctl_img[LO_SEL_LSB +: SEL_W]    = s_q.sel[0];
        ctl_img[HI_SEL_LSB +: SEL_W]    = s_q.sel[1];
        ctl_img[OVF_LSB +: N_CNT]       = s_q.ovf;
    end

    assign reg_rdata = reg_sel ? {s_q.cnt[1], s_q.cnt[0]} : ctl_img;
    assign irq       = s_q.ie & (|s_q.ovf);

    // no counting without the current level's enable
    p_priv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !priv_ok) |=> $stable(s_q.cnt));

    // written value lands exactly, increment of that cycle dropped
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> ({s_q.cnt[1], s_q.cnt[0]} == $past(reg_wdata)));

    // flags are sticky without a control write
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctl && (|s_q.ovf)) |=> ((s_q.ovf & $past(s_q.ovf)) == $past(s_q.ovf)));

    // interrupt never fires without its enable
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.ie && s_q.ovf != '0));

endmodule

// File: tb/sim_pmu_dual_counter.sv
module sim_pmu_dual_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [1:0]  priv = 2'd0;
    logic [4:0]  ev = '0;   // [0] cycle [1] instr [2] cache acc [3] cache miss [4] dtlb miss
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pmu_dual_counter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .priv         (priv),
        .ev_cycle     (ev[0]),
        .ev_instr     (ev[1]),
        .ev_cache_acc (ev[2]),
        .ev_cache_miss(ev[3]),
        .ev_dtlb_miss (ev[4]),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [63:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [63:0] data);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic pulse(input logic [4:0] m, input int n);
        @(negedge clk);
        ev = m;
        repeat (n) @(negedge clk);
        ev = '0;
    endtask

    function automatic logic [63:0] ctl(input int ie, input int en, input int lo, input int hi);
        return 64'(ie & 1) | (64'(en & 7) << 1) | (64'(lo & 63) << 4) | (64'(hi & 63) << 11);
    endfunction

    // R6/R7/R8 expected decode
    function automatic int exp_hit(input int code, input bit upper, input int evb);
        if (code == 'h00) return (evb == 0) ? 1 : 0;
        if (code == 'h01) return (evb == 1) ? 1 : 0;
        if (code == 'h09) return (evb == (upper ? 3 : 2)) ? 1 : 0;
        if (code == 'h12) return (upper && evb == 4) ? 1 : 0;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(1'b0, r); chk("R1 ctl", r, 64'h0);
        rd_reg(1'b1, r); chk("R1 cnt", r, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);

        // R4 layout and unused bits
        wr_reg(1'b0, '1);
        rd_reg(1'b0, r); chk("R4 ctl image", r, 64'h1FBFF);

        // R2 whole-word write and readback
        wr_reg(1'b0, ctl(0, 7, 'h14, 'h1C));
        wr_reg(1'b1, 64'h1234_5678_9ABC_DEF0);
        rd_reg(1'b1, r); chk("R2 readback", r, 64'h1234_5678_9ABC_DEF0);
        wr_reg(1'b1, 64'h0000_0000_FFFF_0000);
        rd_reg(1'b1, r); chk("R2 both halves replaced", r, 64'h0000_0000_FFFF_0000);

        // R6 R7 R8 sweep of every code, every strobe, both halves
        for (int up = 0; up < 2; up++) begin
            for (int code = 0; code < 64; code++) begin
                wr_reg(1'b0, up ? ctl(0, 7, 'h14, code) : ctl(0, 7, code, 'h1C));
                for (int evb = 0; evb < 5; evb++) begin
                    logic [63:0] e;
                    wr_reg(1'b1, 64'h0000_0010_0000_0020);
                    pulse(5'(1 << evb), 3);
                    e = 64'h0000_0010_0000_0020;
                    if (up) e[63:32] = e[63:32] + 32'(3 * exp_hit(code, 1'b1, evb));
                    else    e[31:0]  = e[31:0]  + 32'(3 * exp_hit(code, 1'b0, evb));
                    rd_reg(1'b1, r);
                    chk($sformatf("R6/R7/R8 code=%0h up=%0d ev=%0d", code, up, evb), r, e);
                end
            end
        end

        // R5 privilege gating sweep
        for (int en = 0; en < 8; en++) begin
            wr_reg(1'b0, ctl(0, en, 0, 0));
            for (int p = 0; p < 4; p++) begin
                int on;
                on = ((p == 0 && en[1]) || (p == 1 && en[0]) || (p == 2 && en[2])) ? 1 : 0;
                wr_reg(1'b1, 64'h0);
                priv = 2'(p);
                pulse(5'b00001, 2);
                rd_reg(1'b1, r);
                chk($sformatf("R5 en=%0d priv=%0d", en, p), r, {32'(2*on), 32'(2*on)});
            end
        end
        priv = 2'd0;

        // R3 wrap detection, R11 gating, R10 clearing
        wr_reg(1'b0, ctl(0, 7, 0, 0));
        wr_reg(1'b1, 64'hFFFF_FFFD_FFFF_FFFE);
        pulse(5'b00001, 1);
        rd_reg(1'b0, r); chk("R3 no flag before wrap", r[33:32], 2'b00);
        pulse(5'b00001, 1);
        rd_reg(1'b1, r); chk("R3 lower wrapped", r, 64'hFFFF_FFFF_0000_0000);
        rd_reg(1'b0, r); chk("R3 lower flag", r[33:32], 2'b01);
        chk("R11 irq off without enable", {63'h0, irq}, 64'h0);
        pulse(5'b00001, 1);
        rd_reg(1'b0, r); chk("R3 upper flag", r[33:32], 2'b11);
        wr_reg(1'b0, ctl(1, 7, 0, 0));
        chk("R11 irq with enable", {63'h0, irq}, 64'h1);
        rd_reg(1'b0, r); chk("R10 zero write keeps flags", r[33:32], 2'b11);
        wr_reg(1'b0, ctl(1, 7, 0, 0) | (64'h1 << 32));
        rd_reg(1'b0, r); chk("R10 clear lower only", r[33:32], 2'b10);
        chk("R11 irq still on", {63'h0, irq}, 64'h1);
        wr_reg(1'b0, ctl(1, 7, 0, 0) | (64'h1 << 33));
        rd_reg(1'b0, r); chk("R10 clear upper", r[33:32], 2'b00);
        chk("R11 irq off", {63'h0, irq}, 64'h0);

        // R10 wrap and clear in the same cycle: flag stays set
        wr_reg(1'b1, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        ev = 5'b00001; reg_wr = 1'b1; reg_sel = 1'b0;
        reg_wdata = ctl(1, 7, 0, 0) | (64'h3 << 32);
        @(negedge clk);
        ev = '0; reg_wr = 1'b0;
        rd_reg(1'b0, r); chk("R10 set wins over clear", r[33:32], 2'b01);
        wr_reg(1'b0, ctl(0, 7, 0, 0) | (64'h3 << 32));

        // R9 write and event in the same cycle
        wr_reg(1'b1, 64'h0);
        @(negedge clk);
        ev = 5'b00001; reg_wr = 1'b1; reg_sel = 1'b1;
        reg_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        ev = '0; reg_wr = 1'b0;
        rd_reg(1'b1, r); chk("R9 written value kept", r, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_reg(1'b0, r); chk("R9 no overflow on write cycle", r[33:32], 2'b00);

        // R12 sampling period
        for (int n = 1; n <= 6; n++) begin
            logic [31:0] neg;
            neg = 32'(-n);
            wr_reg(1'b0, ctl(0, 7, 0, 1) | (64'h3 << 32));
            wr_reg(1'b1, {neg, neg});
            if (n > 1) begin
                pulse(5'b00011, n - 1);
                rd_reg(1'b0, r); chk($sformatf("R12 n=%0d early", n), r[33:32], 2'b00);
            end
            pulse(5'b00011, 1);
            rd_reg(1'b0, r); chk($sformatf("R12 n=%0d fires", n), r[33:32], 2'b11);
        end

        finish_run();
    end

endmodule